// File: doc/BRIEF.md
# Banked Interrupt Enable and Routing Controller

This block gathers 32 hardware interrupt lines and turns them into three request outputs: a normal and a fast interrupt for the main CPU, and one interrupt for a coprocessor. A line is pending when its input is high or when software has forced it. The CPU and the coprocessor each have their own enable mask. A per-line class bit sends an enabled CPU line either to the normal output or to the fast output.

Software reaches the state through a simple 32-bit register bus. The enable masks and the force bits never take a direct write. Software changes them only through write-one-to-set and write-one-to-clear offsets, so a driver can alter one line without a read-modify-write. The two class registers take plain writes. One read-only offset shows which lines are at that moment asserting the fast CPU output. A driver can save a mask by reading it and restore it later: it clears every bit, then writes the saved value to the set offset. Several copies of the block can sit side by side, one for each group of 32 lines. Line n belongs to copy n/32, at bit n mod 32.

Top module: `irq_route_bank`

## Requirements
- R1: After reset the force bits, both enable masks and both class registers are zero, all three interrupt outputs are low, and every readable offset returns zero.
- R2: A write to 0x24, 0x34 or 0x18 sets every bit given as 1 in the CPU enable mask, the coprocessor enable mask or the force bits, in that order. Bits given as 0 keep their value. The result reads back at 0x20, 0x30 and 0x14.
- R3: A write to 0x28, 0x38 or 0x1C clears every bit given as 1 in the CPU enable mask, the coprocessor enable mask or the force bits, in that order. An all-ones write empties the whole mask.
- R4: A write to 0x2C or 0x3C loads the CPU or the coprocessor class register with the whole data word. Each reads back at its own offset.
- R5: A line is pending when its input or its force bit is 1. cpu_irq_o is high when at least one line is pending, enabled in the CPU mask and has CPU class bit 0.
- R6: cpu_fiq_o is high when at least one line is pending, enabled in the CPU mask and has CPU class bit 1.
- R7: cop_irq_o is high when at least one line is pending and enabled in the coprocessor mask. The coprocessor class register has no effect on it.
- R8: A read of 0x08 returns, for each line, pending AND CPU enabled AND CPU class bit 1.
- R9: Writes to the read-only offsets 0x08, 0x14, 0x20 and 0x30 change no state. Reads of the write-only offsets, of unmapped offsets, and any cycle without a read request return zero on rdata_o.
- R10: A write to the set or clear offset of one enable mask leaves the other enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32 | Raw interrupt lines, one per bit |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| cpu_irq_o | output | 1 | CPU normal interrupt |
| cpu_fiq_o | output | 1 | CPU fast interrupt |
| cop_irq_o | output | 1 | Coprocessor interrupt |

## Verification
The assertions check on every cycle that a set write leaves its bits set and a clear write leaves them clear. They also check that writes to read-only offsets and writes to the other mask leave the mask stable. Two further properties: an empty coprocessor mask keeps cop_irq_o low, and the fast status read never shows a line of class 0. Only the bench scenarios can show the full routing of each line pattern to the right output. They also cover forced lines appearing and disappearing, the coprocessor class having no effect, and a save, clear-all and restore of a mask returning the exact earlier value.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_FIQ_STAT  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_FORCE     = 6'h14;
  localparam logic [OFF_W-1:0] OFF_FORCE_SET = 6'h18;
  localparam logic [OFF_W-1:0] OFF_FORCE_CLR = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_CPU_EN    = 6'h20;
  localparam logic [OFF_W-1:0] OFF_CPU_SET   = 6'h24;
  localparam logic [OFF_W-1:0] OFF_CPU_CLR   = 6'h28;
  localparam logic [OFF_W-1:0] OFF_CPU_CLS   = 6'h2C;
  localparam logic [OFF_W-1:0] OFF_COP_EN    = 6'h30;
  localparam logic [OFF_W-1:0] OFF_COP_SET   = 6'h34;
  localparam logic [OFF_W-1:0] OFF_COP_CLR   = 6'h38;
  localparam logic [OFF_W-1:0] OFF_COP_CLS   = 6'h3C;

  // state register slots
  localparam int unsigned NREG    = 5;
  localparam int unsigned REG_FRC = 0;
  localparam int unsigned REG_CEN = 1;
  localparam int unsigned REG_CCL = 2;
  localparam int unsigned REG_PEN = 3;
  localparam int unsigned REG_PCL = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LOAD = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irq_state_reg.sv
module irq_state_reg
  import irq_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    case (op_i)
      OP_SET:  q_d = q_q | wdata_i;
      OP_CLR:  q_d = q_q & ~wdata_i;
      OP_LOAD: q_d = wdata_i;
      default: q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_bank_pkg::*;
(
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [OFF_W-1:0]     addr_i,
  output reg_op_e [NREG-1:0]   ops_o
);
  always_comb begin
    for (int i = 0; i < NREG; i++) ops_o[i] = OP_NONE;
    if (req_i && we_i) begin
      case (addr_i)
        OFF_FORCE_SET: ops_o[REG_FRC] = OP_SET;
        OFF_FORCE_CLR: ops_o[REG_FRC] = OP_CLR;
        OFF_CPU_SET:   ops_o[REG_CEN] = OP_SET;
        OFF_CPU_CLR:   ops_o[REG_CEN] = OP_CLR;
        OFF_CPU_CLS:   ops_o[REG_CCL] = OP_LOAD;
        OFF_COP_SET:   ops_o[REG_PEN] = OP_SET;
        OFF_COP_CLR:   ops_o[REG_PEN] = OP_CLR;
        OFF_COP_CLS:   ops_o[REG_PCL] = OP_LOAD;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lines_i,
  input  logic [W-1:0] force_i,
  input  logic [W-1:0] cpu_en_i,
  input  logic [W-1:0] cpu_cls_i,
  input  logic [W-1:0] cop_en_i,
  output logic [W-1:0] fiq_vec_o,
  output logic         cpu_irq_o,
  output logic         cpu_fiq_o,
  output logic         cop_irq_o
);
  logic [W-1:0] pend;
  logic [W-1:0] irq_vec;
  logic [W-1:0] cop_vec;

  for (genvar n = 0; n < W; n++) begin : g_line
    assign pend[n]      = lines_i[n] | force_i[n];
    assign irq_vec[n]   = pend[n] & cpu_en_i[n] & ~cpu_cls_i[n];
    assign fiq_vec_o[n] = pend[n] & cpu_en_i[n] &  cpu_cls_i[n];
    assign cop_vec[n]   = pend[n] & cop_en_i[n];
  end

  assign cpu_irq_o = |irq_vec;
  assign cpu_fiq_o = |fiq_vec_o;
  assign cop_irq_o = |cop_vec;
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] irq_lines_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [NLINES-1:0] wdata_i,
  output logic [NLINES-1:0] rdata_o,
  output logic              cpu_irq_o,
  output logic              cpu_fiq_o,
  output logic              cop_irq_o
);
  reg_op_e [NREG-1:0] ops;
  logic [NLINES-1:0]  state_q [NREG];
  logic [NLINES-1:0]  force_q, cpu_en_q, cpu_cls_q, cop_en_q, cop_cls_q;
  logic [NLINES-1:0]  fiq_vec;

  irq_bus_decode u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .ops_o  (ops)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    irq_state_reg #(.W(NLINES)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (ops[r]),
      .wdata_i (wdata_i),
      .q_o     (state_q[r])
    );
  end

  assign force_q   = state_q[REG_FRC];
  assign cpu_en_q  = state_q[REG_CEN];
  assign cpu_cls_q = state_q[REG_CCL];
  assign cop_en_q  = state_q[REG_PEN];
  assign cop_cls_q = state_q[REG_PCL];

  irq_route #(.W(NLINES)) u_route (
    .lines_i   (irq_lines_i),
    .force_i   (force_q),
    .cpu_en_i  (cpu_en_q),
    .cpu_cls_i (cpu_cls_q),
    .cop_en_i  (cop_en_q),
    .fiq_vec_o (fiq_vec),
    .cpu_irq_o (cpu_irq_o),
    .cpu_fiq_o (cpu_fiq_o),
    .cop_irq_o (cop_irq_o)
  );

  // write-only and unmapped offsets read as zero
  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        OFF_FIQ_STAT: rdata_o = fiq_vec;
        OFF_FORCE:    rdata_o = force_q;
        OFF_CPU_EN:   rdata_o = cpu_en_q;
        OFF_CPU_CLS:  rdata_o = cpu_cls_q;
        OFF_COP_EN:   rdata_o = cop_en_q;
        OFF_COP_CLS:  rdata_o = cop_cls_q;
        default:      rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_bank_chk.sv
module irq_route_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [OFF_W-1:0]  addr_i,
  input logic [NLINES-1:0] wdata_i,
  input logic [NLINES-1:0] rdata_o,
  input logic              cop_irq_o,
  input logic [NLINES-1:0] cpu_en_q,
  input logic [NLINES-1:0] cpu_cls_q,
  input logic [NLINES-1:0] cop_en_q
);
  logic wr;
  assign wr = req_i && we_i;

  // R2
  cpu_set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CPU_SET) |=> ((cpu_en_q & $past(wdata_i)) == $past(wdata_i)));

  // R3
  cpu_clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CPU_CLR) |=> ((cpu_en_q & $past(wdata_i)) == '0));

  // R3
  cop_clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_COP_CLR) |=> ((cop_en_q & $past(wdata_i)) == '0));

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (addr_i == OFF_CPU_EN || addr_i == OFF_COP_EN || addr_i == OFF_FIQ_STAT))
    |=> ($stable(cpu_en_q) && $stable(cop_en_q)));

  // R10
  cop_write_keeps_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (addr_i == OFF_COP_SET || addr_i == OFF_COP_CLR)) |=> $stable(cpu_en_q));

  // R10
  cpu_write_keeps_cop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (addr_i == OFF_CPU_SET || addr_i == OFF_CPU_CLR)) |=> $stable(cop_en_q));

  // R7
  cop_quiet_when_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_en_q == '0) |-> !cop_irq_o);

  // R8
  fiq_stat_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_FIQ_STAT) |-> ((rdata_o & ~cpu_cls_q) == '0));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> (rdata_o == '0));
endmodule

bind irq_route_bank irq_route_bank_chk #(.NLINES(NLINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .cop_irq_o (cop_irq_o),
  .cpu_en_q  (cpu_en_q),
  .cpu_cls_q (cpu_cls_q),
  .cop_en_q  (cop_en_q)
);

// File: tb/irq_route_bank_tb.sv
module irq_route_bank_tb;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  lines = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [5:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          cpu_irq, cpu_fiq, cop_irq;

  int            n_cmp = 0, n_bad = 0, cyc = 0;
  string         rd_tag = "R1";
  logic [W-1:0]  saved;

  // reference state
  logic [W-1:0]  m_frc, m_cen, m_ccl, m_pen, m_pcl;

  always #10 clk = ~clk;

  irq_route_bank #(.NLINES(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cpu_irq_o(cpu_irq), .cpu_fiq_o(cpu_fiq), .cop_irq_o(cop_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frc <= '0; m_cen <= '0; m_ccl <= '0; m_pen <= '0; m_pcl <= '0;
    end else if (req && we) begin
      if (addr == 6'h18) m_frc <= m_frc | wdata;
      if (addr == 6'h1C) m_frc <= m_frc & ~wdata;
      if (addr == 6'h24) m_cen <= m_cen | wdata;
      if (addr == 6'h28) m_cen <= m_cen & ~wdata;
      if (addr == 6'h2C) m_ccl <= wdata;
      if (addr == 6'h34) m_pen <= m_pen | wdata;
      if (addr == 6'h38) m_pen <= m_pen & ~wdata;
      if (addr == 6'h3C) m_pcl <= wdata;
    end
  end

  function automatic logic [W-1:0] exp_read(input logic [5:0] a);
    logic [W-1:0] p;
    p = lines | m_frc;
    if (!(req && !we)) return '0;
    if (a == 6'h08) return p & m_cen & m_ccl;
    if (a == 6'h14) return m_frc;
    if (a == 6'h20) return m_cen;
    if (a == 6'h2C) return m_ccl;
    if (a == 6'h30) return m_pen;
    if (a == 6'h3C) return m_pcl;
    return '0;
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [W-1:0] p;
      p = lines | m_frc;
      cmp("R5 cpu_irq", {31'b0, cpu_irq}, {31'b0, |(p & m_cen & ~m_ccl)});
      cmp("R6 cpu_fiq", {31'b0, cpu_fiq}, {31'b0, |(p & m_cen & m_ccl)});
      cmp("R7 cop_irq", {31'b0, cop_irq}, {31'b0, |(p & m_pen)});
      cmp({rd_tag, " rdata"}, rdata, exp_read(addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
    @(posedge clk); #5;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #5;
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(posedge clk); #5;
    rd_tag = tag; req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #5;
    req = 1'b0;
  endtask

  task automatic drive(input logic [W-1:0] v);
    @(posedge clk); #5;
    lines = v;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state, every offset including unmapped (R9)
    for (int a = 0; a < 64; a += 4) rd(6'(a), "R1");

    // R2 set ports
    wr(6'h24, 32'h0000_00F1);
    wr(6'h24, 32'h8000_0100);
    rd(6'h20, "R2");
    wr(6'h34, 32'h0F0F_0000);
    rd(6'h30, "R2");
    rd(6'h20, "R10");
    // R4 class registers
    wr(6'h2C, 32'h0000_00F0);
    rd(6'h2C, "R4");
    wr(6'h3C, 32'hFFFF_0000);
    rd(6'h3C, "R4");

    // R5 / R6 / R7 line patterns
    drive(32'h0000_0001);  // enabled, class 0
    drive(32'h0000_0010);  // enabled, class 1
    rd(6'h08, "R8");
    drive(32'h0000_0004);  // not enabled anywhere
    drive(32'h0100_0000);  // coprocessor only, cop class ignored (R7)
    drive(32'h8000_0011);
    rd(6'h08, "R8");
    drive('0);

    // force bits
    wr(6'h18, 32'h0000_0100);
    rd(6'h14, "R2");
    wr(6'h18, 32'h0000_0020);
    rd(6'h08, "R8");
    wr(6'h1C, 32'h0000_0100);
    rd(6'h14, "R3");
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h14, "R3");

    // R9 read-only offsets ignore writes
    wr(6'h20, 32'h0);
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h20, "R9");
    rd(6'h30, "R9");
    rd(6'h14, "R9");
    rd(6'h24, "R9");
    rd(6'h1C, "R9");

    // R10 clear of one mask leaves the other
    wr(6'h38, 32'h0F00_0000);
    rd(6'h30, "R3");
    rd(6'h20, "R10");

    // save, clear all, restore
    saved = m_cen;
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h20, "R3");
    drive(32'hFFFF_FFFF);
    wr(6'h24, saved);
    rd(6'h20, "R2");
    drive('0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule